// File: doc/BRIEF.md
# Boot Memory Remap Decoder

This block chooses which physical memory answers at the bottom of the processor address space. A one-bit software control, held in an 8-bit memory-mapped register, selects either the flash or the SRAM for the low-address alias. Both memories, and the peripheral space, also stay reachable at their own absolute base addresses. Boot code can therefore run from the absolute flash window while it moves the alias over to SRAM, for example to shorten interrupt entry.

The block has two ports. A simple slave port reads and writes the control register. A decode port takes a processor address and returns one chip select and the offset inside the selected memory. The decode is combinational. The register changes only on a clock edge, so a write affects the access that follows it and never the one in flight. Every reset source clears the control bit, so the reset vector is always fetched from flash. The reset sources are the asynchronous power-on reset and a synchronous reset pulse from the rest of the system.

Top module: `boot_remap_decoder`

## Requirements
- R1: While `rst_n` is low, and after it rises, the control register reads 0x00 and address 0x00000000 selects flash.
- R2: The control register answers only at `REMAP_ADDR` (default 0xFFFF0220). A write with `reg_en` high at that address loads `reg_wdata[0]` into the remap bit. A read returns `{7'b0, remap}`. Accesses at any other address change nothing and read as 0x00.
- R3: Register bits 7:1 are reserved. Writing ones to them has no effect, and they always read as zero.
- R4: With the remap bit at 0, an address below 2^`FLASH_AW` (default 32 KiB) selects flash (`cs_flash`), and `dec_offset` equals the address.
- R5: With the remap bit at 1, an address below 2^`SRAM_AW` (default 4 KiB) selects SRAM (`cs_sram`), and `dec_offset` equals the address.
- R6: Whatever the remap bit holds, an address inside [`FLASH_BASE`, `FLASH_BASE`+2^`FLASH_AW`) selects flash, and `dec_offset` is the address minus `FLASH_BASE` (default base 0x00080000).
- R7: Whatever the remap bit holds, the absolute SRAM window (default base 0x00040000, 4 KiB) selects `cs_sram`. The peripheral window (default base 0xFFFF0000, 64 KiB) selects `cs_periph`. In both cases the offset is taken relative to the window base.
- R8: An address in no window raises `dec_err` with `dec_offset` = 0. This includes addresses between 2^`SRAM_AW` and 2^`FLASH_AW` while the remap bit is 1.
- R9: While `dec_valid` is high, exactly one of `cs_flash`, `cs_sram`, `cs_periph`, `dec_err` is high. While it is low, all four and `dec_offset` are zero.
- R10: A `soft_rst` pulse clears the remap bit at the next clock edge. It wins over a register write in the same cycle.
- R11: A register write changes the decode only from the cycle after its clock edge. The decode in the write cycle still uses the old bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst | input | 1 | Synchronous reset from any other reset source |
| reg_en | input | 1 | Register port access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Register port address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, zero when not reading the register |
| dec_valid | input | 1 | Decode request valid |
| dec_addr | input | AW | Processor address to decode |
| cs_flash | output | 1 | Flash selected |
| cs_sram | output | 1 | SRAM selected |
| cs_periph | output | 1 | Peripheral space selected |
| dec_err | output | 1 | Address hits no window |
| dec_offset | output | AW | Offset inside the selected window |

## Verification
The decode is tried with addresses at the first and last word of each window, and one past the end, under both values of the remap bit. These show whether the alias follows the bit, whether its size follows the selected memory, and whether the absolute windows ignore the bit. Addresses in the gap between the SRAM and flash alias sizes separate a correct size switch from a fixed-size alias. Writes carrying ones in the reserved bits, writes to a neighbouring address, and a reset pulse that coincides with a write check that only the intended path changes the bit. A decode sampled in the cycle of a write checks that the change waits for the next access.

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder #(
  parameter int AW = 32,
  parameter int FLASH_AW = 15,
  parameter int SRAM_AW = 12,
  parameter int PERIPH_AW = 16,
  parameter logic [AW-1:0] FLASH_BASE = 'h0008_0000,
  parameter logic [AW-1:0] SRAM_BASE = 'h0004_0000,
  parameter logic [AW-1:0] PERIPH_BASE = 'hFFFF_0000,
  parameter logic [AW-1:0] REMAP_ADDR = 'hFFFF_0220
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          reg_en,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          dec_valid,
  input  logic [AW-1:0] dec_addr,
  output logic          cs_flash,
  output logic          cs_sram,
  output logic          cs_periph,
  output logic          dec_err,
  output logic [AW-1:0] dec_offset
);
  localparam logic [AW-1:0] FLASH_MASK  = {AW{1'b1}} >> (AW - FLASH_AW);
  localparam logic [AW-1:0] SRAM_MASK   = {AW{1'b1}} >> (AW - SRAM_AW);
  localparam logic [AW-1:0] PERIPH_MASK = {AW{1'b1}} >> (AW - PERIPH_AW);

  logic remap_q;
  logic reg_hit;
  logic unused_rsvd;

  assign reg_hit     = reg_en && (reg_addr == REMAP_ADDR);
  assign unused_rsvd = ^reg_wdata[7:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remap_q <= 1'b0;
    else if (soft_rst)         remap_q <= 1'b0;
    else if (reg_hit && reg_wr) remap_q <= reg_wdata[0];
  end

  assign reg_rdata = (reg_hit && !reg_wr) ? {7'd0, remap_q} : 8'd0;

  logic [AW-1:0] alias_mask;
  logic in_alias, in_flash, in_sram, in_periph;

  assign alias_mask = remap_q ? SRAM_MASK : FLASH_MASK;
  assign in_alias   = (dec_addr & ~alias_mask) == '0;
  assign in_flash   = (dec_addr & ~FLASH_MASK) == FLASH_BASE;
  assign in_sram    = (dec_addr & ~SRAM_MASK) == SRAM_BASE;
  assign in_periph  = (dec_addr & ~PERIPH_MASK) == PERIPH_BASE;

  always_comb begin
    cs_flash   = 1'b0;
    cs_sram    = 1'b0;
    cs_periph  = 1'b0;
    dec_err    = 1'b0;
    dec_offset = '0;
    if (dec_valid) begin
      if (in_alias) begin
        cs_sram    = remap_q;
        cs_flash   = !remap_q;
        dec_offset = dec_addr & alias_mask;
      end else if (in_flash) begin
        cs_flash   = 1'b1;
        dec_offset = dec_addr & FLASH_MASK;
      end else if (in_sram) begin
        cs_sram    = 1'b1;
        dec_offset = dec_addr & SRAM_MASK;
      end else if (in_periph) begin
        cs_periph  = 1'b1;
        dec_offset = dec_addr & PERIPH_MASK;
      end else begin
        dec_err    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk #(
  parameter int AW = 32,
  parameter int FLASH_AW = 15,
  parameter logic [AW-1:0] FLASH_BASE = 'h0008_0000,
  parameter logic [AW-1:0] REMAP_ADDR = 'hFFFF_0220
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          reg_en,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          remap_q,
  input logic          dec_valid,
  input logic [AW-1:0] dec_addr,
  input logic          cs_flash,
  input logic          cs_sram,
  input logic          cs_periph,
  input logic          dec_err,
  input logic [AW-1:0] dec_offset
);
  localparam logic [AW-1:0] FM = {AW{1'b1}} >> (AW - FLASH_AW);

  assert_one_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $countones({cs_flash, cs_sram, cs_periph, dec_err}) == 1);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> ({cs_flash, cs_sram, cs_periph, dec_err} == 4'd0 && dec_offset == '0));

  assert_flash_abs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && (dec_addr & ~FM) == FLASH_BASE) |-> (cs_flash && dec_offset == (dec_addr & FM)));

  assert_err_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> dec_offset == '0);

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !remap_q);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !(reg_en && reg_wr && reg_addr == REMAP_ADDR)) |=> $stable(remap_q));
endmodule

bind boot_remap_decoder boot_remap_chk #(
  .AW(AW), .FLASH_AW(FLASH_AW), .FLASH_BASE(FLASH_BASE), .REMAP_ADDR(REMAP_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_en(reg_en), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .remap_q(remap_q), .dec_valid(dec_valid), .dec_addr(dec_addr),
  .cs_flash(cs_flash), .cs_sram(cs_sram), .cs_periph(cs_periph), .dec_err(dec_err),
  .dec_offset(dec_offset)
);

// File: tb/tb_boot_remap_decoder.sv
module tb_boot_remap_decoder;
  localparam logic [31:0] RADDR = 32'hFFFF_0220;
  localparam logic [3:0] F = 4'b1000, S = 4'b0100, P = 4'b0010, E = 4'b0001;
  localparam int NV = 14;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, F, 32'h0000_0000},
    {1'b0, 32'h0000_7FFC, F, 32'h0000_7FFC},
    {1'b0, 32'h0000_8000, E, 32'h0000_0000},
    {1'b0, 32'h0008_0010, F, 32'h0000_0010},
    {1'b0, 32'h0004_0020, S, 32'h0000_0020},
    {1'b0, 32'hFFFF_0220, P, 32'h0000_0220},
    {1'b0, 32'h0010_0000, E, 32'h0000_0000},
    {1'b1, 32'h0000_0000, S, 32'h0000_0000},
    {1'b1, 32'h0000_0FFC, S, 32'h0000_0FFC},
    {1'b1, 32'h0000_1000, E, 32'h0000_0000},
    {1'b1, 32'h0008_7FFC, F, 32'h0000_7FFC},
    {1'b1, 32'h0004_0FFF, S, 32'h0000_0FFF},
    {1'b1, 32'h0004_1000, E, 32'h0000_0000},
    {1'b1, 32'hFFFF_FFFF, P, 32'h0000_FFFF}
  };

  logic clk = 0, rst_n = 0, soft_rst = 0, reg_en = 0, reg_wr = 0, dec_valid = 0;
  logic [31:0] reg_addr = 0, dec_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic cs_flash, cs_sram, cs_periph, dec_err;
  logic [31:0] dec_offset;
  int n_checks = 0, n_fail = 0;

  always #10 clk = ~clk;

  boot_remap_decoder dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dec_valid(dec_valid), .dec_addr(dec_addr), .cs_flash(cs_flash), .cs_sram(cs_sram),
    .cs_periph(cs_periph), .dec_err(dec_err), .dec_offset(dec_offset)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_wr = 0;
  endtask

  task automatic reg_read(input logic [31:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 0; reg_addr = a;
    #2 d = reg_rdata;
    reg_en = 0;
  endtask

  task automatic decode(input logic [31:0] a, output logic [35:0] r);
    @(negedge clk);
    dec_valid = 1; dec_addr = a;
    #2 r = {cs_flash, cs_sram, cs_periph, dec_err, dec_offset};
    dec_valid = 0;
  endtask

  initial begin
    logic [7:0] rd;
    logic [35:0] dr;
    #5;
    check("R1 reset rdata", {56'd0, reg_rdata}, 64'd0);
    reg_en = 1; reg_addr = RADDR; #1;
    check("R1 reset read", {56'd0, reg_rdata}, 64'd0);
    reg_en = 0;
    repeat (2) @(posedge clk);
    rst_n = 1;
    reg_read(RADDR, rd);
    check("R1 after reset", {56'd0, rd}, 64'd0);
    decode(32'h0, dr);
    check("R1 low addr flash", {28'd0, dr}, {28'd0, F, 32'h0});

    for (int i = 0; i < NV; i++) begin
      reg_write(RADDR, {7'd0, VEC[i][68]});
      decode(VEC[i][67:36], dr);
      check(VEC[i][68] ? "R5/R6/R7/R8 table remap=1" : "R4/R6/R7/R8 table remap=0",
            {28'd0, dr}, {28'd0, VEC[i][35:0]});
    end

    reg_write(RADDR, 8'h00);
    reg_write(RADDR, 8'hFF);
    reg_read(RADDR, rd);
    check("R3 reserved bits read zero", {56'd0, rd}, 64'h01);
    reg_write(RADDR, 8'hFE);
    reg_read(RADDR, rd);
    check("R3 reserved bits ignored", {56'd0, rd}, 64'h00);

    reg_write(RADDR + 32'd4, 8'h01);
    reg_read(RADDR, rd);
    check("R2 other address ignored", {56'd0, rd}, 64'h00);
    reg_read(RADDR + 32'd4, rd);
    check("R2 other address reads zero", {56'd0, rd}, 64'h00);
    reg_write(RADDR, 8'h01);
    reg_read(RADDR, rd);
    check("R2 write sets bit", {56'd0, rd}, 64'h01);

    @(negedge clk);
    dec_valid = 0; dec_addr = 32'h0;
    #2 check("R9 idle outputs", {28'd0, cs_flash, cs_sram, cs_periph, dec_err, dec_offset}, 64'd0);

    reg_write(RADDR, 8'h00);
    @(negedge clk);
    reg_en = 1; reg_wr = 1; reg_addr = RADDR; reg_wdata = 8'h01;
    dec_valid = 1; dec_addr = 32'h0;
    #2 check("R11 write cycle uses old bit", {60'd0, cs_flash, cs_sram, cs_periph, dec_err}, {60'd0, F});
    @(negedge clk);
    reg_en = 0; reg_wr = 0;
    #2 check("R11 next access uses new bit", {60'd0, cs_flash, cs_sram, cs_periph, dec_err}, {60'd0, S});
    dec_valid = 0;

    @(negedge clk);
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    reg_read(RADDR, rd);
    check("R10 soft reset clears", {56'd0, rd}, 64'h00);
    decode(32'h0, dr);
    check("R10 flash after soft reset", {28'd0, dr}, {28'd0, F, 32'h0});

    @(negedge clk);
    soft_rst = 1; reg_en = 1; reg_wr = 1; reg_addr = RADDR; reg_wdata = 8'h01;
    @(negedge clk);
    soft_rst = 0; reg_en = 0; reg_wr = 0;
    reg_read(RADDR, rd);
    check("R10 soft reset beats write", {56'd0, rd}, 64'h00);

    reg_write(RADDR, 8'h01);
    @(negedge clk);
    rst_n = 0;
    #2;
    reg_en = 1; reg_wr = 0; reg_addr = RADDR; #1;
    check("R1 async reset clears", {56'd0, reg_rdata}, 64'h00);
    reg_en = 0;
    @(negedge clk);
    rst_n = 1;
    decode(32'h0, dr);
    check("R1 flash after async reset", {28'd0, dr}, {28'd0, F, 32'h0});

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule